// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a 16-bit timer counter whose behaviour is chosen by a 4-bit mode code. Each mode belongs to one of four families:

- **Free-running:** counts up through the full range.
- **Clear-on-match:** counts up to a programmable TOP, then returns to zero.
- **Fast single-slope:** counts up to TOP, then returns to zero, with overflow reported at TOP.
- **Dual-slope:** counts up to TOP and back down to zero.

TOP comes from one of three sources: a fixed constant, the capture register value, or the compare-A register value. Both register values are plain inputs driven from elsewhere in the chip.

The counter only advances on enabled count ticks. A tick comes either from a free-running prescaler with a selectable division or from an external single-cycle count pulse.

The block keeps three sticky event flags: overflow, compare-A-at-TOP and capture-at-TOP. Each flag is cleared by a write-one-to-clear pulse on its bit. The block also gives one-cycle strobes for the count ticks on which the counter sits at TOP or at zero. All pins are plain control and status signals; the block has no streaming interface.

Top module: `mmtimer_core`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, `down_o` is 0 and all three flags are 0.
- R2: Modes 0 and 13 count up on every tick from 0 to 0xFFFF and then wrap to 0. The overflow flag is set by the tick taken at 0xFFFF. In these modes `capt_val_i` and `cmpa_val_i` have no effect.
- R3: In mode 4, TOP is `cmpa_val_i`; in mode 12, TOP is `capt_val_i`. In both modes, the tick taken at TOP reloads 0. That tick sets the compare-A flag in mode 4 and the capture flag in mode 12. The overflow flag is also set on that tick, but only when TOP is 0xFFFF.
- R4: The fast single-slope modes count up only and reload 0 after TOP. Their TOP values are:
  - mode 5: 0x00FF
  - mode 6: 0x01FF
  - mode 7: 0x03FF
  - mode 14: `capt_val_i`
  - mode 15: `cmpa_val_i`

  The overflow flag is set by the tick taken at TOP. In mode 14 that tick also sets the capture flag, and in mode 15 it also sets the compare-A flag. In modes 5, 6 and 7 the register inputs have no effect.
- R5: The dual-slope modes count 0, 1, …, TOP, TOP-1, …, 0, 1, …, with no repeated endpoint. Their TOP values are:
  - mode 1: 0x00FF
  - mode 2: 0x01FF
  - mode 3: 0x03FF
  - modes 8 and 10: `capt_val_i`
  - modes 9 and 11: `cmpa_val_i`

  `down_o` is 1 while the counter is counting down. In every other mode it is 0.
- R6: In the dual-slope modes, the overflow flag is set by the tick taken at 0 while counting down. The tick taken at TOP while counting up sets the capture flag when TOP comes from `capt_val_i`, and the compare-A flag when TOP comes from `cmpa_val_i`.
- R7: `clk_sel_i` selects the tick source:
  - 0 and 7: no ticks.
  - 1, 2, 3, 4, 5: a tick every 1, 8, 64, 256 or 1024 cycles. The first tick comes in cycle N-1 after reset release, counting that cycle as 0.
  - 6: a tick in each cycle with `ext_tick_i` high.

  Without a tick, the count does not change.
- R8: `flag_clr_i` bit 0 clears the overflow flag, bit 1 the compare-A flag and bit 2 the capture flag; each flag has its own output. A flag stays set until its clear bit is pulsed. A set and a clear in the same cycle leave the flag set. Flags are set only on ticks.
- R9: In the cycle of a tick, `at_top_o` is high if the count equals TOP and the counter is not counting down, and `at_bot_o` is high if the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Counting mode code |
| clk_sel_i | input | 3 | Tick source select (R7) |
| ext_tick_i | input | 1 | External count pulse, one cycle per count |
| capt_val_i | input | 16 | Capture register value, a possible TOP |
| cmpa_val_i | input | 16 | Compare-A register value, a possible TOP |
| flag_clr_i | input | 3 | Write-one-to-clear pulses {capture, compare-A, overflow} |
| count_o | output | 16 | Counter value |
| down_o | output | 1 | 1 while counting down |
| at_top_o | output | 1 | Tick at TOP strobe |
| at_bot_o | output | 1 | Tick at zero strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmpa_flag_o | output | 1 | Sticky compare-A-at-TOP flag |
| capt_flag_o | output | 1 | Sticky capture-at-TOP flag |

## Verification
The properties on the counting step and on the turn at TOP assume that `mode_i`, `capt_val_i` and `cmpa_val_i` are held constant between resets. They also assume the count never sits above TOP. The stimulus meets both assumptions: every scenario applies its mode and register values while reset is asserted and leaves them unchanged until the next reset. Each scenario is compared cycle by cycle against an arithmetic model of the count, direction, strobes and flags. The sweep covers every mode and every tick source, and includes the full 16-bit wrap both in the free-running mode and in the clear-on-match mode with TOP at 0xFFFF.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int FLAG_N = 3;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_CMPA = 1;
  localparam int FLAG_CAPT = 2;

  typedef enum logic [1:0] {FAM_FREE, FAM_CLEAR, FAM_FAST, FAM_DUAL} fam_e;
  typedef enum logic [2:0] {TOP_MAX, TOP_8B, TOP_9B, TOP_10B, TOP_CAPT, TOP_CMPA} topsrc_e;

  typedef struct packed {
    fam_e    fam;
    topsrc_e src;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c.fam = FAM_FREE;
    c.src = TOP_MAX;
    case (m)
      4'd1:  begin c.fam = FAM_DUAL;  c.src = TOP_8B;   end
      4'd2:  begin c.fam = FAM_DUAL;  c.src = TOP_9B;   end
      4'd3:  begin c.fam = FAM_DUAL;  c.src = TOP_10B;  end
      4'd4:  begin c.fam = FAM_CLEAR; c.src = TOP_CMPA; end
      4'd5:  begin c.fam = FAM_FAST;  c.src = TOP_8B;   end
      4'd6:  begin c.fam = FAM_FAST;  c.src = TOP_9B;   end
      4'd7:  begin c.fam = FAM_FAST;  c.src = TOP_10B;  end
      4'd8:  begin c.fam = FAM_DUAL;  c.src = TOP_CAPT; end
      4'd9:  begin c.fam = FAM_DUAL;  c.src = TOP_CMPA; end
      4'd10: begin c.fam = FAM_DUAL;  c.src = TOP_CAPT; end
      4'd11: begin c.fam = FAM_DUAL;  c.src = TOP_CMPA; end
      4'd12: begin c.fam = FAM_CLEAR; c.src = TOP_CAPT; end
      4'd14: begin c.fam = FAM_FAST;  c.src = TOP_CAPT; end
      4'd15: begin c.fam = FAM_FAST;  c.src = TOP_CMPA; end
      default: begin c.fam = FAM_FREE; c.src = TOP_MAX; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);
  localparam int NTAP = 5;

  function automatic int tap_bits(input int i);
    case (i)
      0: return 0;
      1: return 3;
      2: return 6;
      3: return 8;
      default: return PRE_W;
    endcase
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int B = tap_bits(i);
    if (B == 0) begin : g_div1
      assign hit[i] = 1'b1;
    end else begin : g_divn
      assign hit[i] = &pre_q[B-1:0];
    end
  end

  always_comb begin
    case (sel_i)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5: tick_o = hit[sel_i - 3'd1];
      3'd6:    tick_o = ext_tick_i;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmt_top_sel.sv
module mmt_top_sel
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input  topsrc_e       src_i,
  input  logic [CW-1:0] capt_i,
  input  logic [CW-1:0] cmpa_i,
  output logic [CW-1:0] top_o
);
  always_comb begin
    case (src_i)
      TOP_8B:   top_o = CW'(255);
      TOP_9B:   top_o = CW'(511);
      TOP_10B:  top_o = CW'(1023);
      TOP_CAPT: top_o = capt_i;
      TOP_CMPA: top_o = cmpa_i;
      default:  top_o = '1;
    endcase
  end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dual_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o,
  output logic          down_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      down_o <= 1'b0;
    end else if (!dual_i) begin
      down_o <= 1'b0;
      if (tick_i) cnt_o <= (cnt_o == top_i) ? '0 : cnt_o + 1'b1;
    end else if (tick_i) begin
      if (!down_o) begin
        if (cnt_o >= top_i) begin
          if (cnt_o != '0) begin
            cnt_o  <= cnt_o - 1'b1;
            down_o <= 1'b1;
          end
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end else if (cnt_o == '0) begin
        cnt_o  <= (top_i == '0) ? '0 : CW'(1);
        down_o <= 1'b0;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmt_flags.sv
module mmt_flags
  import mmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_cfg_t         cfg_i,
  input  logic              top_hit_i,
  input  logic              bot_hit_i,
  input  logic              down_i,
  input  logic              top_max_i,
  input  logic [FLAG_N-1:0] clr_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] set_w;

  always_comb begin
    set_w = '0;
    case (cfg_i.fam)
      FAM_FREE:  set_w[FLAG_OVF] = top_hit_i;
      FAM_CLEAR: set_w[FLAG_OVF] = top_hit_i & top_max_i;
      FAM_FAST:  set_w[FLAG_OVF] = top_hit_i;
      default:   set_w[FLAG_OVF] = bot_hit_i & down_i;
    endcase
    set_w[FLAG_CMPA] = top_hit_i & (cfg_i.src == TOP_CMPA);
    set_w[FLAG_CAPT] = top_hit_i & (cfg_i.src == TOP_CAPT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_w;
  end
endmodule

// File: rtl/mmtimer_core.sv
module mmtimer_core
  import mmt_pkg::*;
#(
  parameter int CW    = 16,
  parameter int PRE_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    mode_i,
  input  logic [2:0]    clk_sel_i,
  input  logic          ext_tick_i,
  input  logic [CW-1:0] capt_val_i,
  input  logic [CW-1:0] cmpa_val_i,
  input  logic [2:0]    flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic          down_o,
  output logic          at_top_o,
  output logic          at_bot_o,
  output logic          ovf_flag_o,
  output logic          cmpa_flag_o,
  output logic          capt_flag_o
);
  mode_cfg_t         cfg_w;
  logic              tick_w;
  logic              dual_w;
  logic [CW-1:0]     top_w;
  logic [FLAG_N-1:0] flags_w;

  assign cfg_w  = decode_mode(mode_i);
  assign dual_w = (cfg_w.fam == FAM_DUAL);

  mmt_prescaler #(.PRE_W(PRE_W)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(clk_sel_i),
    .ext_tick_i(ext_tick_i), .tick_o(tick_w)
  );

  mmt_top_sel #(.CW(CW)) topsel_i (
    .src_i(cfg_w.src), .capt_i(capt_val_i), .cmpa_i(cmpa_val_i), .top_o(top_w)
  );

  mmt_counter #(.CW(CW)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .dual_i(dual_w),
    .top_i(top_w), .cnt_o(count_o), .down_o(down_o)
  );

  assign at_top_o = tick_w & ~down_o & (count_o == top_w);
  assign at_bot_o = tick_w & (count_o == '0);

  mmt_flags flags_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_w),
    .top_hit_i(at_top_o), .bot_hit_i(at_bot_o), .down_i(down_o),
    .top_max_i(&top_w), .clr_i(flag_clr_i), .flags_o(flags_w)
  );

  assign ovf_flag_o  = flags_w[FLAG_OVF];
  assign cmpa_flag_o = flags_w[FLAG_CMPA];
  assign capt_flag_o = flags_w[FLAG_CAPT];
endmodule

// File: rtl/mmtimer_core_chk.sv
module mmtimer_core_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          dual_i,
  input logic [CW-1:0] count_i,
  input logic [CW-1:0] top_i,
  input logic          down_i,
  input logic [2:0]    flags_i,
  input logic [2:0]    clr_i
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (count_i == '0 && !down_i && flags_i == 3'b000));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dual_i && count_i != top_i) |=> (count_i == $past(count_i) + 1'b1));

  a_r5_turn_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dual_i && !down_i && count_i == top_i && top_i != '0)
      |=> (down_i && count_i == $past(count_i) - 1'b1));

  a_r6_ovf_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dual_i && down_i && count_i == '0) |=> flags_i[0]);

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_i));

  a_r8_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && clr_i == 3'b000) |=> $stable(flags_i));
endmodule

bind mmtimer_core mmtimer_core_chk #(.CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .dual_i(dual_w),
  .count_i(count_o), .top_i(top_w), .down_i(down_o),
  .flags_i({capt_flag_o, cmpa_flag_o, ovf_flag_o}), .clr_i(flag_clr_i)
);

// File: tb/mmtimer_core_tb_top.sv
`timescale 1ns/1ps
module mmtimer_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic [2:0]  sel;
  logic        ext;
  logic [15:0] capt, cmpa;
  logic [2:0]  clr;
  logic [15:0] count;
  logic        down, at_top, at_bot, ovf, fcmpa, fcapt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state
  int m_cnt, m_pre;
  bit m_down;
  bit [2:0] m_flags;

  always #2.5 clk = ~clk;

  mmtimer_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .clk_sel_i(sel), .ext_tick_i(ext),
    .capt_val_i(capt), .cmpa_val_i(cmpa), .flag_clr_i(clr), .count_o(count),
    .down_o(down), .at_top_o(at_top), .at_bot_o(at_bot), .ovf_flag_o(ovf),
    .cmpa_flag_o(fcmpa), .capt_flag_o(fcapt)
  );

  // family: 0 free, 1 clear-on-match, 2 fast, 3 dual
  function automatic int fam_of(input int md);
    case (md)
      1, 2, 3, 8, 9, 10, 11: return 3;
      4, 12:                 return 1;
      5, 6, 7, 14, 15:       return 2;
      default:               return 0;
    endcase
  endfunction

  // 0 fixed, 1 capture, 2 compare A
  function automatic int src_of(input int md);
    case (md)
      8, 10, 12, 14: return 1;
      4, 9, 11, 15:  return 2;
      default:       return 0;
    endcase
  endfunction

  function automatic int top_of(input int md, input int cv, input int av);
    case (md)
      1, 5:   return 255;
      2, 6:   return 511;
      3, 7:   return 1023;
      8, 10, 12, 14: return cv;
      4, 9, 11, 15:  return av;
      default: return 65535;
    endcase
  endfunction

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {count,down,top,bot,flags} actual=%h expected=%h at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic scenario(input string req, input int md, input int s, input int cv,
                          input int av, input int ncyc, input int clr_at, input int ext_per);
    int fam, src, top, n;
    bit tick, th, bh;
    bit [2:0] setv, clrv;
    @(negedge clk);
    rst_n = 1'b0;
    mode = 4'(md); sel = 3'(s); capt = 16'(cv); cmpa = 16'(av);
    clr = 3'b000; ext = 1'b0;
    @(negedge clk);
    check("R1 reset", {count, down, 1'b0, 1'b0, fcapt, fcmpa, ovf}, 22'h0);
    rst_n = 1'b1;
    m_cnt = 0; m_pre = 0; m_down = 1'b0; m_flags = 3'b000;
    fam = fam_of(md); src = src_of(md); top = top_of(md, cv, av);
    case (s)
      1: n = 1; 2: n = 8; 3: n = 64; 4: n = 256; 5: n = 1024; default: n = 0;
    endcase
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) @(negedge clk);
      clrv = (k == clr_at) ? 3'b111 : 3'b000;
      clr = clrv;
      ext = (ext_per != 0) && (k % ext_per == 0);
      #1;
      if (s == 6)     tick = ext;
      else if (n > 0) tick = ((m_pre % n) == n - 1);
      else            tick = 1'b0;
      th = tick && !m_down && (m_cnt == top);
      bh = tick && (m_cnt == 0);
      check(req, {count, down, at_top, at_bot, fcapt, fcmpa, ovf},
            {16'(m_cnt), m_down, th, bh, m_flags});
      setv = 3'b000;
      case (fam)
        0: setv[0] = th;
        1: setv[0] = th && (top == 65535);
        2: setv[0] = th;
        default: setv[0] = bh && m_down;
      endcase
      setv[1] = th && (src == 2);
      setv[2] = th && (src == 1);
      m_flags = (m_flags & ~clrv) | setv;
      m_pre = (m_pre + 1) % 1024;
      if (tick) begin
        if (fam != 3) begin
          m_cnt = (m_cnt == top) ? 0 : (m_cnt + 1) % 65536;
        end else if (!m_down) begin
          if (m_cnt >= top) begin
            if (m_cnt != 0) begin m_cnt = m_cnt - 1; m_down = 1'b1; end
          end else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          m_cnt = (top == 0) ? 0 : 1; m_down = 1'b0;
        end else m_cnt = m_cnt - 1;
      end
      if (fam != 3) m_down = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    mode = 4'd0; sel = 3'd0; ext = 1'b0; capt = '0; cmpa = '0; clr = '0;
    // R2 free-running full wrap and reserved mode
    scenario("R2 mode0 wrap", 0, 1, 7, 9, 65545, -1, 0);
    scenario("R2 mode13", 13, 1, 3, 3, 40, -1, 0);
    // R3 clear on match
    scenario("R3 mode4", 4, 1, 2, 6, 40, -1, 0);
    scenario("R3 mode12", 12, 1, 5, 2, 40, -1, 0);
    scenario("R3 mode4 top max", 4, 1, 3, 65535, 65545, -1, 0);
    // R4 fast single slope
    scenario("R4 mode5", 5, 1, 3, 4, 2 * 256 + 10, -1, 0);
    scenario("R4 mode6", 6, 1, 3, 4, 2 * 512 + 10, -1, 0);
    scenario("R4 mode7", 7, 1, 3, 4, 2 * 1024 + 10, -1, 0);
    scenario("R4 mode14", 14, 1, 6, 2, 40, -1, 0);
    scenario("R4 mode15", 15, 1, 2, 7, 40, -1, 0);
    // R5 R6 dual slope
    scenario("R5 R6 mode1", 1, 1, 3, 4, 2 * 255 + 10, -1, 0);
    scenario("R5 R6 mode2", 2, 1, 3, 4, 2 * 511 + 10, -1, 0);
    scenario("R5 R6 mode3", 3, 1, 3, 4, 2 * 1023 + 10, -1, 0);
    scenario("R5 R6 mode8", 8, 1, 5, 2, 60, -1, 0);
    scenario("R5 R6 mode9", 9, 1, 2, 4, 60, -1, 0);
    scenario("R5 R6 mode10", 10, 1, 3, 9, 60, -1, 0);
    scenario("R5 R6 mode11", 11, 1, 9, 6, 60, -1, 0);
    // R7 tick sources
    scenario("R7 sel0 stopped", 0, 0, 0, 0, 50, -1, 2);
    scenario("R7 sel7 stopped", 0, 7, 0, 0, 50, -1, 2);
    scenario("R7 div8", 0, 2, 0, 0, 300, -1, 0);
    scenario("R7 div64", 5, 3, 0, 0, 700, -1, 0);
    scenario("R7 div256", 0, 4, 0, 0, 1100, -1, 0);
    scenario("R7 div1024", 0, 5, 0, 0, 2100, -1, 0);
    scenario("R7 external", 4, 6, 0, 3, 100, -1, 3);
    // R8 flag clearing and set priority
    scenario("R8 clear idle", 12, 1, 4, 0, 30, 7, 0);
    scenario("R8 set wins", 12, 1, 4, 0, 30, 9, 0);
    scenario("R8 dual clear", 11, 1, 0, 3, 40, 8, 0);
    scenario("R8 slow clear", 4, 2, 0, 1, 60, 20, 0);
    // R9 strobes
    scenario("R9 strobes", 15, 1, 0, 3, 30, -1, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(195000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule